// File: doc/BRIEF.md
# Colour Look-Up Table Host Access Port

This block is the processor side of a 256-entry colour look-up table. Each entry holds a red, a green and a blue component of 10 bits. A host reaches the table, a mode register and a small bank of control registers through one narrow port. That port has a 2-bit target select, a write strobe, a read strobe, a 10-bit write bus and a registered 10-bit read bus.

Palette entries are never addressed per component. The host loads the 8-bit address register once and then makes three palette accesses. An internal component pointer steps through them in red, green, blue order. After the blue access the address register steps to the next entry, so a long run of triplets streams through consecutive entries and wraps from FFh to 00h. The pointer is a three-state machine. PTR_RED moves to PTR_GREEN on a palette access. PTR_GREEN moves to PTR_BLUE on a palette access. PTR_BLUE returns to PTR_RED on a palette access, which also increments the address. Every state is forced to PTR_RED by a write to the address register. Palette writes are staged and reach the table as one 30-bit word on the blue write.

A bit in the mode register chooses between full 10-bit components and 8-bit components. In 8-bit mode a written byte becomes the top of the component and a read returns the top byte right-justified. The control bank is indexed by the same address register. It holds five read/write registers, a fixed identity value and a fixed revision value, and every other index reads as zero.

Top module: `clut_host_port`

## Requirements
- R1: After reset the address register, the mode register, the five writable control registers and `rdata` are all zero, and the component pointer is at red.
- R2: `sel` encodes the target: 00 address register, 01 palette data, 10 control register indexed by the address register, 11 mode register. A write to target 00 or 11 loads `wdata[7:0]`. A read of target 00, 10 or 11 returns the 8-bit value zero-extended to 10 bits.
- R3: Palette accesses, reads and writes alike, step the component pointer red to green to blue and back to red.
- R4: A write to the address register returns the component pointer to red, whatever its state.
- R5: A blue palette access increments the address register by one. Red and green palette accesses, and all control and mode accesses, leave the address register unchanged.
- R6: A blue palette access at address FFh leaves the address register at 00h.
- R7: Palette writes to red and green are only staged. The 30-bit entry at the current address is written on the blue write, using the staged red and green values. A triplet cut short by an address write leaves the entry unchanged.
- R8: A palette read returns the component the pointer selects from the entry at the current address.
- R9: Mode bit 0 set selects 10-bit components: the full `wdata` is written, and the full 10-bit component is read.
- R10: Mode bit 0 clear selects 8-bit components. A write stores `{wdata[7:0], 2'b00}` and ignores `wdata[9:8]`. A read returns component bits 9:2 on `rdata[7:0]`, with `rdata[9:8]` zero.
- R11: Control indices 0 to 4 are writable registers (pixel mask, three command registers, test). Index 5 reads the identity value 71h and index 6 the revision value 0Ah. Both ignore writes. Indices 7 to FFh read zero and ignore writes. Control and mode accesses do not move the component pointer.
- R12: `rdata` is loaded one clock after a cycle with `rd_en` high and `wr_en` low, and holds its value otherwise. When both strobes are high, the write takes place and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Target select (00 address, 01 palette, 10 control, 11 mode) |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Registered read data |

## Verification
Two functions land on the same clock edge: the blue write that commits a whole entry, and the address step to the next entry. The commit must use the address from before the step. The bench provokes this by writing two entries back to back across FFh to 00h. It judges the result by reloading FFh and reading all six components back, then reading the address register to confirm the wrap. A second collision, both strobes high in one cycle, is judged by checking that `rdata` keeps its previous value while the address register takes the written value.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PTR_RED   = 2'd0,
        PTR_GREEN = 2'd1,
        PTR_BLUE  = 2'd2
    } comp_ptr_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_PAL  = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_MODE = 2'b11
    } port_sel_e;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          pal_acc,
    output comp_ptr_e     ptr,
    output logic [AW-1:0] addr
);

    comp_ptr_e     ptr_q, ptr_d;
    logic [AW-1:0] addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= PTR_RED;
        else        ptr_q <= ptr_d;
    end

    // next state
    always_comb begin
        ptr_d = ptr_q;
        if (addr_we) begin
            ptr_d = PTR_RED;
        end else if (pal_acc) begin
            unique case (ptr_q)
                PTR_RED:   ptr_d = PTR_GREEN;
                PTR_GREEN: ptr_d = PTR_BLUE;
                PTR_BLUE:  ptr_d = PTR_RED;
                default:   ptr_d = PTR_RED;
            endcase
        end
    end

    // outputs: the entry address, stepping after the blue access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we) begin
            addr_q <= addr_wdata;
        end else if (pal_acc && ptr_q == PTR_BLUE) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign addr = addr_q;

endmodule

// File: rtl/clut_lut.sv
module clut_lut
    import clut_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          comp_we,
    input  comp_ptr_e     ptr,
    input  logic [CW-1:0] comp_wdata,
    input  logic [AW-1:0] addr,
    output logic [CW-1:0] comp_rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int EW    = 3 * CW;

    logic [CW-1:0] stage_r, stage_g;
    logic [EW-1:0] mem [DEPTH];
    logic [EW-1:0] entry;

    // red and green wait here until the blue write arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_r <= '0;
            stage_g <= '0;
        end else if (comp_we) begin
            if (ptr == PTR_RED)   stage_r <= comp_wdata;
            if (ptr == PTR_GREEN) stage_g <= comp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (comp_we && ptr == PTR_BLUE) begin
            mem[addr] <= {stage_r, stage_g, comp_wdata};
        end
    end

    always_comb begin
        entry = mem[addr];
        unique case (ptr)
            PTR_RED:   comp_rdata = entry[EW-1 -: CW];
            PTR_GREEN: comp_rdata = entry[2*CW-1 -: CW];
            PTR_BLUE:  comp_rdata = entry[CW-1:0];
            default:   comp_rdata = '0;
        endcase
    end

endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank #(
    parameter int          IDX_W   = 8,
    parameter int          RW      = 8,
    parameter int          NUM_RW  = 5,
    parameter int unsigned ID_VAL  = 'h71,
    parameter int unsigned REV_VAL = 'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [RW-1:0]    wdata,
    output logic [RW-1:0]    rdata
);

    localparam int ID_IDX  = NUM_RW;
    localparam int REV_IDX = NUM_RW + 1;

    logic [RW-1:0] regs [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             regs[g] <= '0;
            else if (we && idx == IDX_W'(g))        regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (idx == IDX_W'(i)) rdata = regs[i];
        end
        if (idx == IDX_W'(ID_IDX))  rdata = RW'(ID_VAL);
        if (idx == IDX_W'(REV_IDX)) rdata = RW'(REV_VAL);
    end

endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          CW       = 10,
    parameter int          NW       = 8,
    parameter int          NUM_RW   = 5,
    parameter int unsigned ID_VAL   = 'h71,
    parameter int unsigned REV_VAL  = 'h0A,
    parameter int          WIDE_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata
);

    localparam int RW = AW;

    port_sel_e     sel_e;
    logic          rd_act, pal_acc, addr_we, ctrl_we, pal_we;
    logic          wide;
    logic [RW-1:0] mode_q;
    logic [AW-1:0] addr_cur;
    comp_ptr_e     ptr_cur;
    logic [CW-1:0] comp_wr, comp_rd_raw, pal_rd;
    logic [RW-1:0] ctrl_rd;
    logic [CW-1:0] rdata_q;

    assign sel_e   = port_sel_e'(sel);
    assign rd_act  = rd_en && !wr_en;
    assign pal_acc = (wr_en || rd_act) && sel_e == SEL_PAL;
    assign pal_we  = wr_en && sel_e == SEL_PAL;
    assign addr_we = wr_en && sel_e == SEL_ADDR;
    assign ctrl_we = wr_en && sel_e == SEL_CTRL;
    assign wide    = mode_q[WIDE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mode_q <= '0;
        else if (wr_en && sel_e == SEL_MODE) mode_q <= wdata[RW-1:0];
    end

    clut_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (addr_we),
        .addr_wdata (wdata[AW-1:0]),
        .pal_acc    (pal_acc),
        .ptr        (ptr_cur),
        .addr       (addr_cur)
    );

    if (CW > NW) begin : g_narrow
        localparam int PAD = CW - NW;
        always_comb begin
            comp_wr = wide ? wdata : {wdata[NW-1:0], {PAD{1'b0}}};
            pal_rd  = wide ? comp_rd_raw : {{PAD{1'b0}}, comp_rd_raw[CW-1:PAD]};
        end
    end else begin : g_full
        assign comp_wr = wdata;
        assign pal_rd  = comp_rd_raw;
    end

    clut_lut #(.AW(AW), .CW(CW)) u_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .comp_we    (pal_we),
        .ptr        (ptr_cur),
        .comp_wdata (comp_wr),
        .addr       (addr_cur),
        .comp_rdata (comp_rd_raw)
    );

    clut_ctrl_bank #(
        .IDX_W   (AW),
        .RW      (RW),
        .NUM_RW  (NUM_RW),
        .ID_VAL  (ID_VAL),
        .REV_VAL (REV_VAL)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .idx   (addr_cur),
        .wdata (wdata[RW-1:0]),
        .rdata (ctrl_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_act) begin
            unique case (sel_e)
                SEL_ADDR: rdata_q <= CW'(addr_cur);
                SEL_PAL:  rdata_q <= pal_rd;
                SEL_CTRL: rdata_q <= CW'(ctrl_rd);
                SEL_MODE: rdata_q <= CW'(mode_q);
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk
    import clut_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CW     = 10,
    parameter int NW     = 8,
    parameter int NUM_RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic [CW-1:0] rdata,
    input logic [AW-1:0] addr,
    input comp_ptr_e     ptr,
    input logic          wide
);

    logic pal_acc, rd_only;
    assign rd_only = rd_en && !wr_en;
    assign pal_acc = (wr_en || rd_en) && sel == 2'b01;

    // R3
    red_to_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_acc && ptr == PTR_RED |=> ptr == PTR_GREEN);

    // R4
    addr_wr_ptr_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sel == 2'b00 |=> ptr == PTR_RED);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_acc && ptr == PTR_BLUE |=> addr == AW'($past(addr) + 1'b1));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_acc && ptr != PTR_BLUE |=> $stable(addr));

    // R6
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_acc && ptr == PTR_BLUE && addr == '1 |=> addr == '0);

    // R10
    narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && sel == 2'b01 && !wide |=> rdata[CW-1:NW] == '0);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && sel == 2'b10 && addr > AW'(NUM_RW + 1) |=> rdata == '0);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(rdata));

endmodule

bind clut_host_port clut_host_port_chk #(
    .AW(AW), .CW(CW), .NW(NW), .NUM_RW(NUM_RW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .addr  (addr_cur),
    .ptr   (ptr_cur),
    .wide  (wide)
);

// File: tb/clut_host_port_bench.sv
module clut_host_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [9:0] last_exp = '0;

    localparam logic [1:0] S_ADDR = 2'b00, S_PAL = 2'b01, S_CTRL = 2'b10, S_MODE = 2'b11;

    always #10 clk = ~clk;

    clut_host_port u_clut_host_port (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [9:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [9:0] e, input string tag);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: result appears on the edge that takes the read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !wr_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("R12 unexpected read", rdata, 10'h000);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", rdata, 10'h000);
        rd(S_ADDR, 10'h000, "R1 address reset");
        rd(S_MODE, 10'h000, "R1 mode reset");
        rd(S_CTRL, 10'h000, "R1 pixel mask reset");

        // 10-bit mode
        wr(S_MODE, 10'h3C1);
        rd(S_MODE, 10'h0C1, "R2 mode readback zero-extended");
        wr(S_ADDR, 10'h010);
        wr(S_PAL, 10'h3A5); wr(S_PAL, 10'h155); wr(S_PAL, 10'h2AA);
        rd(S_ADDR, 10'h011, "R5 step after blue write");
        wr(S_ADDR, 10'h010);
        rd(S_PAL, 10'h3A5, "R8 R9 red");
        rd(S_ADDR, 10'h010, "R5 hold after red");
        rd(S_PAL, 10'h155, "R3 green");
        rd(S_PAL, 10'h2AA, "R3 blue");
        rd(S_ADDR, 10'h011, "R5 step after blue read");

        // R4: address write mid-triplet
        wr(S_ADDR, 10'h010);
        rd(S_PAL, 10'h3A5, "R4 red before reload");
        wr(S_ADDR, 10'h010);
        rd(S_PAL, 10'h3A5, "R4 red after reload");

        // R7: interrupted triplet does not commit
        wr(S_ADDR, 10'h020);
        wr(S_PAL, 10'h001); wr(S_PAL, 10'h002); wr(S_PAL, 10'h003);
        wr(S_ADDR, 10'h020);
        wr(S_PAL, 10'h3FF); wr(S_PAL, 10'h3FE);
        wr(S_ADDR, 10'h020);
        rd(S_PAL, 10'h001, "R7 red kept");
        rd(S_PAL, 10'h002, "R7 green kept");
        rd(S_PAL, 10'h003, "R7 blue kept");

        // R6: commit and step together across the wrap
        wr(S_ADDR, 10'h0FF);
        wr(S_PAL, 10'h001); wr(S_PAL, 10'h002); wr(S_PAL, 10'h003);
        wr(S_PAL, 10'h3FC); wr(S_PAL, 10'h3FD); wr(S_PAL, 10'h3FE);
        rd(S_ADDR, 10'h001, "R6 address after wrap");
        wr(S_ADDR, 10'h0FF);
        rd(S_PAL, 10'h001, "R6 entry FF red");
        rd(S_PAL, 10'h002, "R6 entry FF green");
        rd(S_PAL, 10'h003, "R6 entry FF blue");
        rd(S_PAL, 10'h3FC, "R6 entry 00 red");
        rd(S_PAL, 10'h3FD, "R6 entry 00 green");
        rd(S_PAL, 10'h3FE, "R6 entry 00 blue");

        // R10: 8-bit components
        wr(S_MODE, 10'h000);
        wr(S_ADDR, 10'h030);
        wr(S_PAL, 10'h3AB); wr(S_PAL, 10'h0CD); wr(S_PAL, 10'h012);
        wr(S_MODE, 10'h001);
        wr(S_ADDR, 10'h030);
        rd(S_PAL, 10'h2AC, "R10 red stored shifted");
        rd(S_PAL, 10'h334, "R10 green stored shifted");
        rd(S_PAL, 10'h048, "R10 blue stored shifted");
        wr(S_MODE, 10'h000);
        wr(S_ADDR, 10'h030);
        rd(S_PAL, 10'h0AB, "R10 red narrow read");
        rd(S_PAL, 10'h0CD, "R10 green narrow read");
        rd(S_PAL, 10'h012, "R10 blue narrow read");
        wr(S_MODE, 10'h001);

        // R11: control bank
        wr(S_ADDR, 10'h000); wr(S_CTRL, 10'h05A);
        wr(S_ADDR, 10'h003); wr(S_CTRL, 10'h0C3);
        wr(S_ADDR, 10'h000);
        rd(S_CTRL, 10'h05A, "R11 pixel mask");
        wr(S_ADDR, 10'h003);
        rd(S_CTRL, 10'h0C3, "R11 command 3");
        wr(S_ADDR, 10'h005); wr(S_CTRL, 10'h0FF);
        rd(S_CTRL, 10'h071, "R11 identity read-only");
        wr(S_ADDR, 10'h006);
        rd(S_CTRL, 10'h00A, "R11 revision");
        wr(S_ADDR, 10'h007); wr(S_CTRL, 10'h0FF);
        rd(S_CTRL, 10'h000, "R11 reserved zero");
        wr(S_ADDR, 10'h080);
        rd(S_CTRL, 10'h000, "R11 high reserved zero");

        // R11: control and mode reads leave the pointer alone
        wr(S_ADDR, 10'h010);
        rd(S_PAL,  10'h3A5, "R11 red");
        rd(S_CTRL, 10'h000, "R11 index 10 reserved");
        rd(S_MODE, 10'h001, "R11 mode between");
        rd(S_PAL,  10'h155, "R11 green still next");
        rd(S_PAL,  10'h2AA, "R11 blue");
        rd(S_ADDR, 10'h011, "R11 address stepped once");

        // R12: both strobes at once
        @(negedge clk);
        sel = S_ADDR; wdata = 10'h044; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R12 rdata held on write plus read", rdata, last_exp);
        rd(S_ADDR, 10'h044, "R12 write took effect");

        repeat (4) @(negedge clk);
        check("R12 queue drained", 10'(exp_q.size()), 10'h000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule